// File: doc/BRIEF.md
# OUT Endpoint Receive Handshake Controller

This block decides, for a USB device with a set of OUT endpoints, what happens to each OUT transaction. It sees an OUT token with its endpoint number. It checks the endpoint's enable and isochronous configuration and its own record of whether that endpoint's receive buffer is occupied. It then tracks the data phase to its end and chooses between storing the data, discarding it with a NAK, or storing it and answering with an ACK. Isochronous endpoints never answer.

Each successful reception marks the endpoint's buffer full and raises that endpoint's interrupt flag. The OR of all flags drives the interrupt line. The microprocessor finds the endpoint from the flag vector, clears flags by writing ones, and empties buffers by writing ones to a separate mask. Bit-level line coding, CRC checking and the packet memory are outside the block. The data-phase verdict arrives as `rx_ok` together with `rx_done`.

The sequencer has five states. S_IDLE waits for a token. S_RECV tracks a data phase that will be stored. S_SINK tracks a data phase that will be discarded. S_ACK drives the ACK for one cycle. S_NAK drives the NAK for one cycle. The transitions are:
- T_ACCEPT: S_IDLE to S_RECV, on a token for an enabled endpoint with an empty buffer.
- T_BUSY: S_IDLE to S_SINK, on a token for an enabled endpoint with a full buffer.
- T_GOOD: S_RECV to S_ACK, when a good data phase ends on a non-isochronous endpoint.
- T_ISO_DONE: S_RECV to S_IDLE, when a good data phase ends on an isochronous endpoint.
- T_BAD: S_RECV to S_IDLE, when the data phase ends with an error.
- T_REFUSE: S_SINK to S_NAK, for a non-isochronous endpoint.
- T_DROP: S_SINK to S_IDLE, for an isochronous endpoint.
- T_ACK_DONE: S_ACK to S_IDLE.
- T_NAK_DONE: S_NAK to S_IDLE.

Top module: `oep_rx_ctrl`

## Requirements
- R1: After reset all buffer-full bits and interrupt flags are 0, `irq` is 0, and neither `hsk_ack` nor `hsk_nak` is asserted.
- R2: A token for an endpoint whose `ep_enable` bit is 0 causes no handshake and no change to buffer or interrupt state, and the block stays ready for the next token.
- R3: A token for an enabled, non-isochronous endpoint with an empty buffer, followed by `rx_done` with `rx_ok`=1, sets `buf_full[ep]` at the `rx_done` edge. `hsk_ack` is then high for exactly the one following cycle.
- R4: For a non-isochronous reception, `int_flags[ep]` is set at the clock edge that ends the `hsk_ack` cycle. `irq` is the OR of all `int_flags` bits.
- R5: An accepted good reception on an isochronous endpoint (`ep_iso` bit 1) sends no handshake. It sets both `buf_full[ep]` and `int_flags[ep]` at the `rx_done` edge.
- R6: A token for an enabled non-isochronous endpoint whose buffer is full discards the data phase. `hsk_nak` is high for the one cycle after `rx_done`, and neither buffer nor interrupt state changes.
- R7: A token for an enabled isochronous endpoint whose buffer is full sends no handshake and changes no state.
- R8: A data phase ending with `rx_ok`=0 leaves the buffer empty and sends neither ACK nor NAK. It raises no interrupt.
- R9: A cycle with `int_clr_we`=1 clears every `int_flags` bit set in `int_clr_mask`. A flag set and cleared in the same cycle ends up set.
- R10: A cycle with `buf_empty_we`=1 clears every `buf_full` bit set in `buf_empty_mask`. After that, a new OUT to the endpoint is accepted and acknowledged.
- R11: A token that arrives while a transaction is in progress is ignored.
- R12: The endpoint number and isochronous attribute are captured with the token. A change to `ep_iso` during the data phase does not alter the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | One-cycle OUT token strobe |
| tok_ep | input | EPW | Endpoint number of the token |
| ep_enable | input | NUM_EP | Per-endpoint enable |
| ep_iso | input | NUM_EP | Per-endpoint isochronous attribute |
| rx_done | input | 1 | One-cycle end-of-data-phase strobe |
| rx_ok | input | 1 | Data phase verdict, valid with rx_done |
| int_clr_we | input | 1 | Write strobe for interrupt clearing |
| int_clr_mask | input | NUM_EP | Ones clear the matching interrupt flags |
| buf_empty_we | input | 1 | Write strobe for buffer emptying |
| buf_empty_mask | input | NUM_EP | Ones mark the matching buffers empty |
| hsk_ack | output | 1 | ACK handshake request |
| hsk_nak | output | 1 | NAK handshake request |
| buf_full | output | NUM_EP | Per-endpoint buffer occupied status |
| int_flags | output | NUM_EP | Per-endpoint interrupt flags |
| irq | output | 1 | Interrupt line, OR of the flags |

## Verification
A flag can be raised by the sequencer and cleared by the processor in the same cycle. This happens when the ACK cycle of a reception coincides with a clearing write to that endpoint's bit. The bench provokes it by driving `int_clr_we` with that endpoint's mask during the cycle in which `hsk_ack` is observed high. It then judges that the flag and `irq` are still 1 afterwards, and that a later clear on its own drops them to 0. A token arriving during a data phase, together with an `ep_iso` change in the same window, is also driven to show that both are ignored.

// File: rtl/oep_pkg.sv
package oep_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RECV = 3'd1,
        S_SINK = 3'd2,
        S_ACK  = 3'd3,
        S_NAK  = 3'd4
    } oep_state_t;
endpackage

// File: rtl/oep_flag_bank.sv
module oep_flag_bank #(
    parameter int NUM_EP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] set_vec,
    input  logic [NUM_EP-1:0] clr_vec,
    output logic [NUM_EP-1:0] q
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_vec[i])
                q[i] <= 1'b1;
            else if (clr_vec[i])
                q[i] <= 1'b0;
        end

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> q[i]);
        // R9
        clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !q[i]);
    end
endmodule

// File: rtl/oep_seq.sv
module oep_seq
    import oep_pkg::*;
#(
    parameter int NUM_EP = 8,
    localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [EPW-1:0]    tok_ep,
    input  logic [NUM_EP-1:0] ep_enable,
    input  logic [NUM_EP-1:0] ep_iso,
    input  logic [NUM_EP-1:0] buf_full,
    input  logic              rx_done,
    input  logic              rx_ok,
    output logic              hsk_ack,
    output logic              hsk_nak,
    output logic [NUM_EP-1:0] set_full,
    output logic [NUM_EP-1:0] set_int
);
    oep_state_t state, state_nx;
    logic [EPW-1:0] ep_q;
    logic           iso_q;

    // state register with token capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ep_q  <= '0;
            iso_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && tok_valid) begin
                ep_q  <= tok_ep;
                iso_q <= ep_iso[tok_ep];
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        hsk_ack  = 1'b0;
        hsk_nak  = 1'b0;
        set_full = '0;
        set_int  = '0;
        unique case (state)
            S_IDLE: begin
                if (tok_valid && ep_enable[tok_ep])
                    state_nx = buf_full[tok_ep] ? S_SINK : S_RECV;
            end
            S_RECV: begin
                if (rx_done) begin
                    if (rx_ok) begin
                        set_full[ep_q] = 1'b1;
                        if (iso_q) begin
                            set_int[ep_q] = 1'b1;
                            state_nx = S_IDLE;
                        end else begin
                            state_nx = S_ACK;
                        end
                    end else begin
                        state_nx = S_IDLE;
                    end
                end
            end
            S_SINK: begin
                if (rx_done)
                    state_nx = iso_q ? S_IDLE : S_NAK;
            end
            S_ACK: begin
                hsk_ack = 1'b1;
                set_int[ep_q] = 1'b1;
                state_nx = S_IDLE;
            end
            S_NAK: begin
                hsk_nak = 1'b1;
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsk_ack |=> !hsk_ack);
    // R6
    nak_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsk_nak |-> $past(rx_done));
    // R2
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && tok_valid && !ep_enable[tok_ep]) |=> (state == S_IDLE));
    // R8
    bad_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECV && rx_done && !rx_ok) |=> (state == S_IDLE && !hsk_ack && !hsk_nak));
endmodule

// File: rtl/oep_rx_ctrl.sv
module oep_rx_ctrl #(
    parameter int NUM_EP = 8,
    localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [EPW-1:0]    tok_ep,
    input  logic [NUM_EP-1:0] ep_enable,
    input  logic [NUM_EP-1:0] ep_iso,
    input  logic              rx_done,
    input  logic              rx_ok,
    input  logic              int_clr_we,
    input  logic [NUM_EP-1:0] int_clr_mask,
    input  logic              buf_empty_we,
    input  logic [NUM_EP-1:0] buf_empty_mask,
    output logic              hsk_ack,
    output logic              hsk_nak,
    output logic [NUM_EP-1:0] buf_full,
    output logic [NUM_EP-1:0] int_flags,
    output logic              irq
);
    logic [NUM_EP-1:0] set_full, set_int;
    logic [NUM_EP-1:0] full_clr, int_clr;

    assign full_clr = buf_empty_we ? buf_empty_mask : '0;
    assign int_clr  = int_clr_we ? int_clr_mask : '0;
    assign irq      = |int_flags;

    oep_seq #(.NUM_EP(NUM_EP)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_ep(tok_ep),
        .ep_enable(ep_enable), .ep_iso(ep_iso), .buf_full(buf_full),
        .rx_done(rx_done), .rx_ok(rx_ok),
        .hsk_ack(hsk_ack), .hsk_nak(hsk_nak),
        .set_full(set_full), .set_int(set_int)
    );

    oep_flag_bank #(.NUM_EP(NUM_EP)) i_full (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_full), .clr_vec(full_clr), .q(buf_full)
    );

    oep_flag_bank #(.NUM_EP(NUM_EP)) i_int (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_int), .clr_vec(int_clr), .q(int_flags)
    );

    // R4
    ack_then_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsk_ack |=> irq);
    // R3
    ack_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsk_ack |-> buf_full != '0);
endmodule

// File: tb/test_oep_rx_ctrl.sv
module test_oep_rx_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EP = 8;
    localparam int EPW = 3;
    localparam int NVEC = 8;

    // {ep[3], en, iso, pre, ok, ack, nak, full, int1, int2}
    localparam logic [11:0] VEC [NVEC] = '{
        {3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_valid = 1'b0;
    logic [EPW-1:0] tok_ep = '0;
    logic [NUM_EP-1:0] ep_enable = '0, ep_iso = '0;
    logic rx_done = 1'b0, rx_ok = 1'b0;
    logic int_clr_we = 1'b0, buf_empty_we = 1'b0;
    logic [NUM_EP-1:0] int_clr_mask = '0, buf_empty_mask = '0;
    logic hsk_ack, hsk_nak, irq;
    logic [NUM_EP-1:0] buf_full, int_flags;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oep_rx_ctrl #(.NUM_EP(NUM_EP)) i_oep_rx_ctrl (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .ep_enable(ep_enable), .ep_iso(ep_iso), .rx_done(rx_done), .rx_ok(rx_ok),
        .int_clr_we(int_clr_we), .int_clr_mask(int_clr_mask),
        .buf_empty_we(buf_empty_we), .buf_empty_mask(buf_empty_mask),
        .hsk_ack(hsk_ack), .hsk_nak(hsk_nak), .buf_full(buf_full),
        .int_flags(int_flags), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // captured results of one transaction
    logic a1, n1, a2, n2;
    logic [NUM_EP-1:0] f1, i1, i2;

    task automatic send_out(input logic [EPW-1:0] ep, input logic ok);
        @(negedge clk); tok_valid = 1'b1; tok_ep = ep;
        @(negedge clk); tok_valid = 1'b0;
        @(negedge clk); rx_done = 1'b1; rx_ok = ok;
        @(negedge clk); rx_done = 1'b0; rx_ok = 1'b0;
        a1 = hsk_ack; n1 = hsk_nak; f1 = buf_full; i1 = int_flags;
        @(negedge clk);
        a2 = hsk_ack; n2 = hsk_nak; i2 = int_flags;
    endtask

    task automatic clear_all();
        @(negedge clk);
        int_clr_we = 1'b1; int_clr_mask = '1;
        buf_empty_we = 1'b1; buf_empty_mask = '1;
        @(negedge clk);
        int_clr_we = 1'b0; buf_empty_we = 1'b0;
        int_clr_mask = '0; buf_empty_mask = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 buf_full", buf_full, 0);
        check("R1 int_flags", int_flags, 0);
        check("R1 irq", irq, 0);
        check("R1 handshakes", {hsk_ack, hsk_nak}, 0);
        rst_n = 1'b1;

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [EPW-1:0] ep;
            ep = VEC[v][11:9];
            clear_all();
            ep_iso = '0;
            ep_iso[ep] = VEC[v][7];
            ep_enable = '0;
            if (VEC[v][6]) begin
                ep_enable[ep] = 1'b1;
                send_out(ep, 1'b1);
                @(negedge clk); int_clr_we = 1'b1; int_clr_mask = '1;
                @(negedge clk); int_clr_we = 1'b0; int_clr_mask = '0;
            end
            ep_enable[ep] = VEC[v][8];
            send_out(ep, VEC[v][5]);
            // R2 R3 R5 R6 R7 R8
            check($sformatf("R3/R5-R8 ack vec%0d", v), a1, VEC[v][4]);
            check($sformatf("R6 nak vec%0d", v), n1, VEC[v][3]);
            check($sformatf("R3 full vec%0d", v), f1, VEC[v][2] ? (1 << ep) : 0);
            check($sformatf("R5 early int vec%0d", v), i1, VEC[v][1] ? (1 << ep) : 0);
            check($sformatf("R4 int vec%0d", v), i2, VEC[v][0] ? (1 << ep) : 0);
            check($sformatf("R4 irq vec%0d", v), irq, VEC[v][0]);
            check($sformatf("R3 single ack vec%0d", v), {a2, n2}, 0);
        end

        // R2: block ready right after an ignored token
        clear_all();
        ep_iso = '0; ep_enable = 8'b0000_0010;
        @(negedge clk); tok_valid = 1'b1; tok_ep = 3'd4;
        @(negedge clk); tok_valid = 1'b1; tok_ep = 3'd1;
        @(negedge clk); tok_valid = 1'b0;
        @(negedge clk); rx_done = 1'b1; rx_ok = 1'b1;
        @(negedge clk); rx_done = 1'b0;
        check("R2 ready after ignored token", {hsk_ack, buf_full}, {1'b1, 8'b0000_0010});
        @(negedge clk);

        // R9: set and clear in the same cycle, set wins
        clear_all();
        ep_enable = '1; ep_iso = '0;
        @(negedge clk); tok_valid = 1'b1; tok_ep = 3'd3;
        @(negedge clk); tok_valid = 1'b0;
        @(negedge clk); rx_done = 1'b1; rx_ok = 1'b1;
        @(negedge clk); rx_done = 1'b0;
        check("R9 ack cycle", hsk_ack, 1);
        int_clr_we = 1'b1; int_clr_mask = 8'b0000_1000;
        @(negedge clk); int_clr_we = 1'b0; int_clr_mask = '0;
        check("R9 set wins flag", int_flags, 8'b0000_1000);
        check("R9 set wins irq", irq, 1);
        int_clr_we = 1'b1; int_clr_mask = 8'b0000_1000;
        @(negedge clk); int_clr_we = 1'b0; int_clr_mask = '0;
        check("R9 w1c clears", {irq, int_flags}, 0);

        // R10: full -> NAK, empty -> accepted again
        send_out(3'd3, 1'b1);
        check("R10 nak while full", {a1, n1}, 2'b01);
        @(negedge clk); buf_empty_we = 1'b1; buf_empty_mask = 8'b0000_1000;
        @(negedge clk); buf_empty_we = 1'b0; buf_empty_mask = '0;
        check("R10 emptied", buf_full, 0);
        send_out(3'd3, 1'b1);
        check("R10 ack after empty", {a1, n1, f1[3]}, 3'b101);

        // R11 R12: token during data phase and iso change ignored
        clear_all();
        ep_iso = '0;
        @(negedge clk); tok_valid = 1'b1; tok_ep = 3'd1;
        @(negedge clk); tok_ep = 3'd2; ep_iso = 8'b0000_0010;
        @(negedge clk); tok_valid = 1'b0;
        @(negedge clk); rx_done = 1'b1; rx_ok = 1'b1;
        @(negedge clk); rx_done = 1'b0;
        check("R11 only first endpoint filled", buf_full, 8'b0000_0010);
        check("R12 iso change ignored, ack sent", hsk_ack, 1);
        @(negedge clk);
        check("R12 int after ack", int_flags, 8'b0000_0010);
        check("R11 idle afterwards", {hsk_ack, hsk_nak}, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule